// File: doc/BRIEF.md
# Page-Granular DMA Window Allocator

This block keeps track of which pages of a DMA address window are handed out. It holds one occupancy bit per translation-table entry and serves one request at a time. There are three request kinds. An allocation finds a run of N free pages and marks them used. A free releases N pages starting at a given entry. A reserve marks a fixed range as used, for regions that must never be handed to a device.

Allocation is next-fit. The search starts at a hint that points just past the previous successful allocation and runs to the end of the window. When that search finds no run, the block raises a one-cycle flush request for the downstream translation cache. It waits for the acknowledge and then searches once more from entry zero. The bitmap is scanned one entry per clock. A run-length counter restarts at every occupied entry.

Top module: `dma_page_alloc`

## Requirements
- R1: Opcode encoding on `reqOp` is 0 allocate, 1 free, 2 reserve, 3 invalid. An allocation of N pages returns `okFlag`=1 and, on `resIndex`, the lowest entry at or above the hint that begins N consecutive free entries inside the window, when such a run exists.
- R2: When the first search finds no run, `flushReq` is high for exactly one cycle. The block then waits for `flushAck` and searches again from entry 0, returning the lowest fitting entry in the whole window.
- R3: When the second search also fails, the result is `okFlag`=0 and `errFlag`=0, and neither the bitmap nor the hint changes.
- R4: A successful allocation marks its N entries used and moves the hint to the returned entry plus N. The hint never exceeds the window size and is 0 after reset.
- R5: A reserve whose start entry is at or beyond the window size is ignored: `okFlag`=0, `errFlag`=0, and no entry changes.
- R6: A reserve that runs past the end of the window is clipped at the window size. Every entry in the clipped range becomes used. The result is `okFlag`=1, with `errFlag`=1 when any of those entries was already used.
- R7: A request with a count of 0, or with opcode 3, returns `okFlag`=0 and `errFlag`=1 and changes nothing.
- R8: A free with entry plus count within the window marks those entries free and returns `okFlag`=1, with `errFlag`=1 when any of them was already free.
- R9: A free whose entry plus count exceeds the window size returns `okFlag`=0 and `errFlag`=1 and changes nothing.
- R10: A request is accepted only while `busy` is low. `busy` stays high from the cycle after acceptance through the single-cycle `done` pulse, and falls in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when `busy` is low |
| reqOp | input | 2 | Request kind (0 allocate, 1 free, 2 reserve, 3 invalid) |
| reqEntry | input | IDX_W | Start entry for free and reserve |
| reqCount | input | IDX_W | Number of pages |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| okFlag | output | 1 | Request applied, valid with `done` |
| errFlag | output | 1 | Illegal request or bit-state mismatch, valid with `done` |
| resIndex | output | IDX_W | Allocated entry, valid with `done` and `okFlag` on allocations |
| flushReq | output | 1 | One-cycle translation-cache flush request |
| flushAck | input | 1 | Flush completion from the cache |

## Verification
The bench sweeps allocation sizes until the hint reaches the end of the window. Each flush-and-retry is therefore exercised with a run that exists only below the hint, and also with a run that does not exist anywhere. A design that kept the hint on failure, or skipped the flush, would return a wrong entry or a wrong flush count. Reserves that overlap existing entries, reserves clipped at the window end, and reserves starting beyond it are followed by frees over the same entries, so any bit written or left untouched by mistake shows up as an error flag. Zero counts, the invalid opcode, double frees and frees that run past the end are applied with the model's bitmap unchanged. A design that altered state on any of these would diverge from the model on a later allocation.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OP_ALLOC   = 2'd0,
    OP_FREE    = 2'd1,
    OP_RESERVE = 2'd2,
    OP_BAD     = 2'd3
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic scanStep;
    logic scanRestart;
    logic commitAlloc;
    logic walkStep;
    logic finish;
    logic finOk;
    logic finErr;
    logic finAcc;
  } ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic reqIllegal;
    logic reqIgnore;
    logic scanEnd;
    logic scanHit;
    logic walkEnd;
  } stat_t;
endpackage

// File: rtl/dpa_datapath.sv
module dpa_datapath
  import dpa_pkg::*;
#(
  parameter int TBL   = 32,
  parameter int IDX_W = $clog2(TBL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [1:0]       reqOp,
  input  logic [IDX_W-1:0] reqEntry,
  input  logic [IDX_W-1:0] reqCount,
  output stat_t            stat,
  output logic [IDX_W-1:0] resIndex,
  output logic             okFlag,
  output logic             errFlag
);
  localparam int AW = (TBL > 1) ? $clog2(TBL) : 1;
  localparam logic [IDX_W:0]   TBL_WIDE = (IDX_W + 1)'(TBL);
  localparam logic [IDX_W-1:0] TBL_IDX  = IDX_W'(TBL);

  logic [TBL-1:0]   bitmap;
  logic [TBL-1:0]   allocMask;
  logic [IDX_W-1:0] cursor, runLen, hint, cntQ, limQ, offset;
  opcode_e          opQ;
  logic             accErr;
  logic             curBit;
  logic [IDX_W:0]   reqEnd;
  opcode_e          reqOpE;

  assign reqOpE = opcode_e'(reqOp);
  assign reqEnd = {1'b0, reqEntry} + {1'b0, reqCount};

  // request legality, evaluated on the port values in the accepting cycle
  assign stat.reqIllegal = (reqCount == '0) || (reqOpE == OP_BAD) ||
                           ((reqOpE == OP_FREE) && (reqEnd > TBL_WIDE));
  assign stat.reqIgnore  = (reqOpE == OP_RESERVE) && (reqEntry >= TBL_IDX);

  assign curBit       = (cursor < TBL_IDX) ? bitmap[cursor[AW-1:0]] : 1'b1;
  assign stat.scanEnd = (cursor == TBL_IDX);
  assign stat.scanHit = !stat.scanEnd && !curBit && ((runLen + 1'b1) == cntQ);
  assign stat.walkEnd = (cursor == limQ);
  assign offset       = cursor + 1'b1 - cntQ;

  // one mask bit per entry covering [offset, offset+cntQ)
  for (genvar gi = 0; gi < TBL; gi++) begin : g_mask
    logic [IDX_W:0] pos;
    assign pos = (IDX_W + 1)'(gi);
    assign allocMask[gi] = (pos >= {1'b0, offset}) &&
                           (pos < ({1'b0, offset} + {1'b0, cntQ}));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitmap   <= '0;
      cursor   <= '0;
      runLen   <= '0;
      hint     <= '0;
      cntQ     <= '0;
      limQ     <= '0;
      opQ      <= OP_ALLOC;
      accErr   <= 1'b0;
      resIndex <= '0;
      okFlag   <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (ctrl.loadReq) begin
        opQ    <= reqOpE;
        cntQ   <= reqCount;
        cursor <= (reqOpE == OP_ALLOC) ? hint : reqEntry;
        runLen <= '0;
        accErr <= 1'b0;
        limQ   <= (reqEnd > TBL_WIDE) ? TBL_IDX : reqEnd[IDX_W-1:0];
      end
      if (ctrl.scanRestart) begin
        cursor <= '0;
        runLen <= '0;
      end
      if (ctrl.scanStep) begin
        cursor <= cursor + 1'b1;
        runLen <= curBit ? '0 : runLen + 1'b1;
      end
      if (ctrl.commitAlloc) begin
        bitmap   <= bitmap | allocMask;
        hint     <= offset + cntQ;
        resIndex <= offset;
      end else if (ctrl.walkStep) begin
        bitmap[cursor[AW-1:0]] <= (opQ != OP_FREE);
        accErr <= accErr | ((opQ == OP_FREE) ? !curBit : curBit);
        cursor <= cursor + 1'b1;
      end
      if (ctrl.finish) begin
        okFlag  <= ctrl.finOk;
        errFlag <= ctrl.finErr | (ctrl.finAcc & accErr);
      end
    end
  end
endmodule

// File: rtl/dpa_control.sv
module dpa_control
  import dpa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  stat_t      stat,
  input  logic       flushAck,
  output ctrl_t      ctrl,
  output logic       busy,
  output logic       done,
  output logic       flushReq
);
  typedef enum logic [2:0] {
    S_IDLE, S_SCAN1, S_FLUSH, S_WAIT, S_SCAN2, S_WALK, S_DONE
  } state_e;

  state_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    ctrl     = '0;
    nxt      = st;
    flushReq = 1'b0;
    done     = 1'b0;
    case (st)
      S_IDLE: if (reqValid) begin
        ctrl.loadReq = 1'b1;
        if (stat.reqIllegal) begin
          ctrl.finish = 1'b1;
          ctrl.finErr = 1'b1;
          nxt = S_DONE;
        end else if (stat.reqIgnore) begin
          ctrl.finish = 1'b1;
          nxt = S_DONE;
        end else if (opcode_e'(reqOp) == OP_ALLOC) begin
          nxt = S_SCAN1;
        end else begin
          nxt = S_WALK;
        end
      end
      S_SCAN1, S_SCAN2: begin
        if (stat.scanEnd) begin
          if (st == S_SCAN1) nxt = S_FLUSH;
          else begin
            ctrl.finish = 1'b1;
            nxt = S_DONE;
          end
        end else if (stat.scanHit) begin
          ctrl.commitAlloc = 1'b1;
          ctrl.finish      = 1'b1;
          ctrl.finOk       = 1'b1;
          nxt = S_DONE;
        end else begin
          ctrl.scanStep = 1'b1;
        end
      end
      S_FLUSH: begin
        flushReq         = 1'b1;
        ctrl.scanRestart = 1'b1;
        nxt = S_WAIT;
      end
      S_WAIT: if (flushAck) nxt = S_SCAN2;
      S_WALK: begin
        if (stat.walkEnd) begin
          ctrl.finish = 1'b1;
          ctrl.finOk  = 1'b1;
          ctrl.finAcc = 1'b1;
          nxt = S_DONE;
        end else begin
          ctrl.walkStep = 1'b1;
        end
      end
      S_DONE: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/dma_page_alloc.sv
module dma_page_alloc
  import dpa_pkg::*;
#(
  parameter int TBL   = 32,
  parameter int IDX_W = $clog2(TBL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [IDX_W-1:0] reqEntry,
  input  logic [IDX_W-1:0] reqCount,
  output logic             busy,
  output logic             done,
  output logic             okFlag,
  output logic             errFlag,
  output logic [IDX_W-1:0] resIndex,
  output logic             flushReq,
  input  logic             flushAck
);
  ctrl_t ctrlBus;
  stat_t statBus;

  dpa_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .stat(statBus), .flushAck(flushAck), .ctrl(ctrlBus),
    .busy(busy), .done(done), .flushReq(flushReq)
  );

  dpa_datapath #(.TBL(TBL), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrlBus), .reqOp(reqOp),
    .reqEntry(reqEntry), .reqCount(reqCount), .stat(statBus),
    .resIndex(resIndex), .okFlag(okFlag), .errFlag(errFlag)
  );
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter int TBL   = 32,
  parameter int IDX_W = $clog2(TBL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic [1:0]       reqOp,
  input logic [IDX_W-1:0] reqEntry,
  input logic [IDX_W-1:0] reqCount,
  input logic             busy,
  input logic             done,
  input logic             okFlag,
  input logic             errFlag,
  input logic [IDX_W-1:0] resIndex,
  input logic             flushReq,
  input logic             flushAck
);
  localparam logic [IDX_W:0] TBL_WIDE = (IDX_W + 1)'(TBL);

  logic [1:0]       lastOp;
  logic [IDX_W-1:0] lastCnt, lastEnt;
  logic             sawFlush, ackSeen;
  logic             accept;

  assign accept = reqValid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastOp <= '0; lastCnt <= '0; lastEnt <= '0;
      sawFlush <= 1'b0; ackSeen <= 1'b0;
    end else begin
      if (accept) begin
        lastOp <= reqOp; lastCnt <= reqCount; lastEnt <= reqEntry;
        sawFlush <= 1'b0; ackSeen <= 1'b0;
      end else begin
        if (flushReq) sawFlush <= 1'b1;
        if (flushAck && sawFlush) ackSeen <= 1'b1;
      end
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_idle_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_flush_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |=> !flushReq);
  p_flush_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |-> busy);
  p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reqCount == '0) |=> (done && errFlag && !okFlag));
  p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reqOp == 2'd2 && {1'b0, reqEntry} >= TBL_WIDE && reqCount != '0)
      |=> (done && !okFlag && !errFlag));
  p_result_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && okFlag && lastOp == 2'd0) |-> (({1'b0, resIndex} + {1'b0, lastCnt}) <= TBL_WIDE));
  p_fail_flushed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lastOp == 2'd0 && !okFlag && !errFlag) |-> (sawFlush && ackSeen));
  p_free_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && okFlag && lastOp == 2'd1) |-> (({1'b0, lastEnt} + {1'b0, lastCnt}) <= TBL_WIDE));
endmodule

bind dma_page_alloc dpa_checker #(.TBL(TBL), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
  .reqEntry(reqEntry), .reqCount(reqCount), .busy(busy), .done(done),
  .okFlag(okFlag), .errFlag(errFlag), .resIndex(resIndex),
  .flushReq(flushReq), .flushAck(flushAck)
);

// File: tb/sim_dma_page_alloc.sv
module sim_dma_page_alloc;
  localparam int TBL   = 32;
  localparam int IDX_W = $clog2(TBL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [IDX_W-1:0] reqEntry = '0, reqCount = '0;
  logic busy, done, okFlag, errFlag, flushReq;
  logic flushAck = 1'b0;
  logic [IDX_W-1:0] resIndex;

  always #4 clk = ~clk;  // 125 MHz

  dma_page_alloc #(.TBL(TBL), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqEntry(reqEntry), .reqCount(reqCount), .busy(busy), .done(done),
    .okFlag(okFlag), .errFlag(errFlag), .resIndex(resIndex),
    .flushReq(flushReq), .flushAck(flushAck)
  );

  int nChecks = 0, nErrors = 0;
  logic hung = 1'b0;
  logic [TBL-1:0] mBits = '0;
  int mHint = 0;

  task automatic check(input string tag, input logic cond, input int act, input int exp);
    nChecks++;
    if (!cond) begin
      nErrors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cache side: acknowledge a flush three cycles after the request
  initial begin
    forever begin
      @(negedge clk);
      if (flushReq) begin
        repeat (3) @(negedge clk);
        flushAck = 1'b1;
        @(negedge clk);
        flushAck = 1'b0;
      end
    end
  end

  function automatic int findRun(input int from, input int n);
    for (int s = from; s + n <= TBL; s++) begin
      logic clr = 1'b1;
      for (int k = 0; k < n; k++) if (mBits[s + k]) clr = 1'b0;
      if (clr) return s;
    end
    return -1;
  endfunction

  task automatic runReq(input int op, input int ent, input int cnt);
    int expOk = 0, expErr = 0, expIdx = -1, expFlush = 0, flushes = 0, waitCyc = 0;
    string tag;
    // model
    if (cnt == 0 || op == 3) begin
      tag = "R7"; expErr = 1;
    end else if (op == 0) begin
      expIdx = findRun(mHint, cnt);
      tag = "R1";
      if (expIdx < 0) begin
        expFlush = 1;
        expIdx = findRun(0, cnt);
        tag = (expIdx < 0) ? "R3" : "R2";
      end
      if (expIdx >= 0) begin
        expOk = 1;
        for (int k = 0; k < cnt; k++) mBits[expIdx + k] = 1'b1;
        mHint = expIdx + cnt;
      end
    end else if (op == 1) begin
      if (ent + cnt > TBL) begin
        tag = "R9"; expErr = 1;
      end else begin
        tag = "R8"; expOk = 1;
        for (int k = 0; k < cnt; k++) begin
          if (!mBits[ent + k]) expErr = 1;
          mBits[ent + k] = 1'b0;
        end
      end
    end else begin
      if (ent >= TBL) tag = "R5";
      else begin
        tag = "R6"; expOk = 1;
        for (int k = ent; k < ent + cnt && k < TBL; k++) begin
          if (mBits[k]) expErr = 1;
          mBits[k] = 1'b1;
        end
      end
    end
    if (hung) return;
    // drive
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqEntry = IDX_W'(ent); reqCount = IDX_W'(cnt);
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 busy after accept", busy == 1'b1, int'(busy), 1);
    while (!done && !hung) begin
      if (flushReq) flushes++;
      @(negedge clk);
      waitCyc++;
      if (waitCyc > 2000) hung = 1'b1;
    end
    if (hung) begin
      check("watchdog", 1'b0, waitCyc, 0);
      return;
    end
    check({tag, " ok"}, okFlag == 1'(expOk), int'(okFlag), expOk);
    check({tag, " err"}, errFlag == 1'(expErr), int'(errFlag), expErr);
    if (op == 0 && cnt != 0) begin
      check({tag, " flush count"}, flushes == expFlush, flushes, expFlush);
      if (expOk) check({tag, " R4 index"}, int'(resIndex) == expIdx, int'(resIndex), expIdx);
    end
    @(negedge clk);
    check("R10 done single cycle", !done && !busy, int'(done) + 2 * int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset busy", !busy, int'(busy), 0);
    check("reset done", !done, int'(done), 0);
    check("reset flushReq", !flushReq, int'(flushReq), 0);

    // R7: zero counts for every opcode, and the invalid opcode
    for (int op = 0; op < 4; op++) runReq(op, 3, 0);
    runReq(3, 0, 2);

    // R5 / R6: reserves beyond, clipped and overlapping
    runReq(2, 32, 3);
    runReq(2, 50, 1);
    runReq(2, 30, 5);
    runReq(2, 8, 4);
    runReq(2, 10, 4);

    // R1..R4: allocation sweep until hint wraps and retries happen
    for (int r = 0; r < 3; r++)
      for (int n = 1; n <= 5; n++) runReq(0, 0, n);

    // R8 / R9: frees with range and double-free cases
    runReq(1, 31, 2);
    runReq(1, 30, 2);
    runReq(1, 30, 2);
    runReq(1, 40, 1);

    // free whole window in chunks, then fill it in one request
    for (int e = 0; e < TBL; e += 4) runReq(1, e, 4);
    runReq(0, 0, TBL);
    runReq(0, 0, 1);
    runReq(0, 0, 40);

    // sparse pattern: only below-hint runs fit
    runReq(1, 0, TBL);
    for (int e = 0; e < TBL; e += 3) runReq(2, e, 1);
    for (int n = 1; n <= 3; n++)
      for (int r = 0; r < 6; r++) runReq(0, 0, n);
    runReq(1, 0, TBL);
    runReq(0, 0, 7);
    runReq(0, 0, 7);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule